// File: doc/BRIEF.md
# GPIO Pin Control and Interrupt Word

This block holds the complete control and status word for a single general-purpose I/O pin. Software reaches the word through a one-cycle write strobe and a combinational read path. The stored word drives the pad's output-enable and output-value lines. It also carries pad bias and drive settings, which the block stores without acting on them. The block takes in the already filtered pin level, shows it as a read-only bit, and watches it for the trigger condition that software has chosen.

Two fields select the trigger. A one-bit style selector chooses level or edge sensing. A two-bit polarity field chooses low/falling, high/rising or, for edges only, both edges. A trigger event sets a sticky interrupt status when the interrupt enable is on. It sets a sticky wake status when the wake enable is on. Software clears each status bit by writing one to it. The interrupt output is asserted only while the status is set, the enable is on and the mask bit is 1 (unmasked). The wake output follows the wake status. A parent block collects these outputs from many pins.

Word layout (bit: meaning): 0 level style (1 level, 0 edge); 2:1 polarity; 3 interrupt enable; 4 interrupt unmask; 5 wake enable; 6 pull-up enable; 7 pull-up strength; 8 pull-down enable; 10:9 drive strength; 11 output enable; 12 output value; 13 pin level (read-only); 14 interrupt status (write 1 to clear); 15 wake status (write 1 to clear); 31:16 read as 0.

Top module: `gpio_pin_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the writable fields and both status bits are 0. The pad outputs, `irq_o` and `wake_o` are therefore 0, and a read returns only the pin level in bit 13.
- R2: A write stores bits 12:0 exactly as written. Bits 31:16 always read 0. Bit 13 always reads the current `pin_i`, whatever value is written to it.
- R3: `pad_oe_o` equals stored bit 11 and `pad_out_o` equals stored bit 12, starting from the cycle after the write.
- R4: In edge style (bit 0 = 0), polarity 00 triggers on a 1-to-0 change of `pin_i` and polarity 01 triggers on a 0-to-1 change. Each change is detected between consecutive clock samples.
- R5: In edge style, polarity 10 triggers on every change of `pin_i`.
- R6: In level style (bit 0 = 1), polarity 00 triggers on every cycle that `pin_i` is 0 and polarity 01 triggers on every cycle that it is 1. If software clears the status while the level persists, the status sets again.
- R7: Polarity 11 in either style, and polarity 10 in level style, never trigger.
- R8: With the interrupt enable (bit 3) at 0, a trigger does not set the interrupt status.
- R9: `irq_o` is 1 only when the interrupt status, the enable (bit 3) and the unmask (bit 4) are all 1. A status latched while masked appears on `irq_o` once the mask bit is set to 1.
- R10: Both status bits are sticky. Writing 1 to bit 14 or bit 15 clears that bit, and writing 0 leaves it unchanged. A trigger in the same cycle as a clear leaves the bit set.
- R11: With the wake enable (bit 5) at 1, a trigger sets the wake status (bit 15), which drives `wake_o`. This happens regardless of the interrupt enable.
- R12: The pull and drive bits (8:6 and 10:9) are stored and read back but do not change the pad outputs, the trigger or the status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | One-cycle write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Current word, including pin level and status |
| pin_i | input | 1 | Filtered, synchronous pin level |
| pad_oe_o | output | 1 | Pad output enable |
| pad_out_o | output | 1 | Pad output value |
| irq_o | output | 1 | Gated interrupt request to the parent block |
| wake_o | output | 1 | Wake status to the parent block |

## Verification
The bench sweeps every combination of trigger style, polarity and enable. Under each combination it drives a pin pattern of rise, hold, clear-while-held and fall, and it compares every cycle against an arithmetic model. A design that mixed up the polarity codes, or that treated polarity 11 as an edge, would latch status on the wrong transitions. A design with the clear taking priority over the set would lose a level interrupt that is still present. The bench also latches a status while masked and then unmasks it, writes zeros to the status bits, and drives the wake path with the interrupt enable off. Each of these exposes a design that gates at the wrong point or treats a status write as a plain store.

// File: rtl/gpio_pin_pkg.sv
package gpio_pin_pkg;
  localparam int WORD_W = 32;
  localparam int B_LVL = 0;
  localparam int B_ACT = 1;
  localparam int ACT_W = 2;
  localparam int B_IEN = 3;
  localparam int B_UNM = 4;
  localparam int B_WEN = 5;
  localparam int B_PU  = 6;
  localparam int B_PUS = 7;
  localparam int B_PD  = 8;
  localparam int B_DRV = 9;
  localparam int B_OE  = 11;
  localparam int B_OV  = 12;
  localparam int CFG_W = 13;
  localparam int B_PIN = 13;
  localparam int B_IST = 14;
  localparam int B_WST = 15;
  localparam int N_STS = 2;

  typedef enum logic [ACT_W-1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;
endpackage

// File: rtl/gpio_trig_det.sv
module gpio_trig_det
  import gpio_pin_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pin_i,
  input  logic             level_i,
  input  logic [ACT_W-1:0] pol_i,
  output logic             event_o
);
  logic pin_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else         pin_q <= pin_i;
  end

  assign rise = pin_i & ~pin_q;
  assign fall = ~pin_i & pin_q;

  always_comb begin
    event_o = 1'b0;
    if (level_i) begin
      unique case (pol_e'(pol_i))
        POL_LOW:  event_o = ~pin_i;
        POL_HIGH: event_o = pin_i;
        default:  event_o = 1'b0;
      endcase
    end else begin
      unique case (pol_e'(pol_i))
        POL_LOW:  event_o = fall;
        POL_HIGH: event_o = rise;
        POL_BOTH: event_o = rise | fall;
        default:  event_o = 1'b0;
      endcase
    end
  end

  p_rsvd_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pol_i == POL_RSVD) |-> !event_o);
  p_both_edge_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && pol_i == POL_BOTH && ($rose(pin_i) || $fell(pin_i))) |-> event_o);
endmodule

// File: rtl/gpio_sticky_bit.sv
module gpio_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  // set wins so a persisting level is never lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;
    else if (clr_i)  q_o <= 1'b0;
  end

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_o && !clr_i) |=> q_o);
  p_clear_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !q_o);
  p_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
endmodule

// File: rtl/gpio_pin_ctl.sv
module gpio_pin_ctl
  import gpio_pin_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [WORD_W-1:0] wr_data_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              pin_i,
  output logic              pad_oe_o,
  output logic              pad_out_o,
  output logic              irq_o,
  output logic              wake_o
);
  logic [CFG_W-1:0] cfg_q;
  logic             trig;
  logic [N_STS-1:0] sts_set, sts_clr, sts_q;
  localparam int STS_POS [N_STS] = '{B_IST, B_WST};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_data_i[CFG_W-1:0];
  end

  gpio_trig_det u_trig (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_i (cfg_q[B_LVL]),
    .pol_i   (cfg_q[B_ACT +: ACT_W]),
    .event_o (trig)
  );

  assign sts_set[0] = trig & cfg_q[B_IEN];
  assign sts_set[1] = trig & cfg_q[B_WEN];

  for (genvar g = 0; g < N_STS; g++) begin : g_sts
    assign sts_clr[g] = wr_en_i & wr_data_i[STS_POS[g]];
    gpio_sticky_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (sts_set[g]),
      .clr_i  (sts_clr[g]),
      .q_o    (sts_q[g])
    );
  end

  always_comb begin
    rd_data_o              = '0;
    rd_data_o[CFG_W-1:0]   = cfg_q;
    rd_data_o[B_PIN]       = pin_i;
    rd_data_o[B_IST]       = sts_q[0];
    rd_data_o[B_WST]       = sts_q[1];
  end

  assign pad_oe_o  = cfg_q[B_OE];
  assign pad_out_o = cfg_q[B_OV];
  assign irq_o     = sts_q[0] & cfg_q[B_IEN] & cfg_q[B_UNM];
  assign wake_o    = sts_q[1];

  p_pad_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (pad_oe_o == $past(wr_data_i[B_OE])) && (pad_out_o == $past(wr_data_i[B_OV])));
  p_no_latch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_q[B_IEN] && !sts_q[0] && !(wr_en_i && wr_data_i[B_IEN])) |=> !sts_q[0]);
  p_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[B_IEN] && !cfg_q[B_LVL] && cfg_q[B_ACT +: ACT_W] == POL_HIGH && $rose(pin_i)) |=> sts_q[0]);
  p_level_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_q[B_IEN] && cfg_q[B_LVL] && cfg_q[B_ACT +: ACT_W] == POL_HIGH && pin_i) |=> sts_q[0]);
  p_upper_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[WORD_W-1:B_WST+1] == '0);
endmodule

// File: tb/gpio_pin_ctl_tb.sv
`timescale 1ns/1ps
module gpio_pin_ctl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        pin_i = 1'b0;
  logic        pad_oe_o, pad_out_o, irq_o, wake_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  logic [12:0] m_cfg = '0;
  logic        m_ist = 1'b0;
  logic        m_wst = 1'b0;
  logic        m_prev = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_pin_ctl u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .rd_data_o(rd_data_o), .pin_i(pin_i), .pad_oe_o(pad_oe_o),
    .pad_out_o(pad_out_o), .irq_o(irq_o), .wake_o(wake_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic p, input logic we, input logic [31:0] d);
    logic ev;
    logic [1:0] a;
    pin_i = p; wr_en_i = we; wr_data_i = d;
    a = m_cfg[2:1];
    if (m_cfg[0]) ev = (a == 2'd0) ? !p : (a == 2'd1) ? p : 1'b0;
    else          ev = (a == 2'd0) ? (m_prev & !p) : (a == 2'd1) ? (!m_prev & p) :
                       (a == 2'd2) ? (m_prev ^ p) : 1'b0;
    m_ist = (ev & m_cfg[3]) | (m_ist & !(we & d[14]));
    m_wst = (ev & m_cfg[5]) | (m_wst & !(we & d[15]));
    if (we) m_cfg = d[12:0];
    m_prev = p;
    @(posedge clk_i); #1;
    wr_en_i = 1'b0;
    @(negedge clk_i);
    chk(tag, "rd_data", rd_data_o, {16'h0, m_wst, m_ist, p, m_cfg});
    chk(tag, "irq", {31'h0, irq_o}, {31'h0, m_ist & m_cfg[3] & m_cfg[4]});
    chk(tag, "wake", {31'h0, wake_o}, {31'h0, m_wst});
    chk(tag, "pad", {30'h0, pad_oe_o, pad_out_o}, {30'h0, m_cfg[11], m_cfg[12]});
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk("R1", "rd_rst", rd_data_o, 32'h0);
    chk("R1", "out_rst", {28'h0, pad_oe_o, pad_out_o, irq_o, wake_o}, 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1", "rd_after", rd_data_o, 32'h0);

    // R2: readback, upper bits zero, pin bit read-only
    step("R2", 1'b1, 1'b1, 32'hFFFF_FFFF);
    step("R2", 1'b0, 1'b1, 32'hA5A5_0A5A);
    step("R2", 1'b0, 1'b1, 32'h0000_0000);

    // R3: pad drive
    step("R3", 1'b0, 1'b1, 32'h0000_0800);
    step("R3", 1'b0, 1'b1, 32'h0000_1800);
    step("R3", 1'b0, 1'b1, 32'h0000_1000);
    step("R3", 1'b0, 1'b1, 32'h0000_0000);

    // sweep style x polarity x enable: R4 R5 R6 R7 R8
    for (int lv = 0; lv < 2; lv++)
      for (int ac = 0; ac < 4; ac++)
        for (int en = 0; en < 2; en++) begin
          logic [31:0] c;
          string t;
          c = lv | (ac << 1) | (en << 3) | ((ac != 3) << 4) | ((ac[0] ^ lv[0]) << 5);
          t = (en == 0) ? "R8" : (ac == 3) ? "R7" : (lv == 1) ? "R6" : (ac == 2) ? "R5" : "R4";
          step(t, 1'b0, 1'b1, c | 32'h0000_C000);
          step(t, 1'b0, 1'b0, 32'h0);
          step(t, 1'b1, 1'b0, 32'h0);
          step(t, 1'b1, 1'b0, 32'h0);
          step(t, 1'b1, 1'b1, c | 32'h0000_4000);
          step(t, 1'b1, 1'b0, 32'h0);
          step(t, 1'b0, 1'b0, 32'h0);
          step(t, 1'b0, 1'b0, 32'h0);
          step(t, 1'b0, 1'b1, c | 32'h0000_C000);
        end

    // R9: latched while masked, then unmasked
    step("R9", 1'b0, 1'b1, 32'h0000_C00A);
    step("R9", 1'b1, 1'b0, 32'h0);
    step("R9", 1'b1, 1'b1, 32'h0000_001A);
    step("R9", 1'b1, 1'b1, 32'h0000_000A);

    // R10: write zero keeps, write one clears, set beats clear
    step("R10", 1'b0, 1'b1, 32'h0000_C01A);
    step("R10", 1'b1, 1'b0, 32'h0);
    step("R10", 1'b1, 1'b1, 32'h0000_001A);
    step("R10", 1'b1, 1'b1, 32'h0000_401A);
    step("R10", 1'b1, 1'b1, 32'h0000_401B);
    step("R10", 1'b1, 1'b1, 32'h0000_401B);
    step("R10", 1'b0, 1'b1, 32'h0000_C01A);

    // R11: wake without interrupt enable
    step("R11", 1'b0, 1'b1, 32'h0000_C024);
    step("R11", 1'b1, 1'b0, 32'h0);
    step("R11", 1'b1, 1'b1, 32'h0000_0024);
    step("R11", 1'b0, 1'b1, 32'h0000_8024);
    step("R11", 1'b0, 1'b0, 32'h0);

    // R12: pad bias/drive bits are inert
    for (int k = 0; k < 32; k++) begin
      logic [31:0] c;
      c = 32'h0000_C800 | (k << 6);
      step("R12", k[0], 1'b1, c);
      step("R12", !k[0], 1'b0, 32'h0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule